// File: doc/BRIEF.md
# Dual-Mode Issue Sequencer

This block decides, clock by clock, when a small Harvard-architecture controller core may move its next instruction out of the fetch stage. The core has four stages, in this order: fetch, decode, execute, writeback. In compatibility mode every instruction holds the fetch slot for a fixed number of clocks. In turbo mode ordinary instructions issue back to back. The cost of each instruction depends on its class and on the active mode. The block also drives the fetch address, the stage valid and advance strobes, a flush strobe for taken jumps and a retire pulse. It forwards a data-RAM value that is still being written back to an execute-stage read of the same address.

The fetch side works like a stream. `stage_vld[0]` is the valid of the instruction waiting in fetch, and `issue_o` is the ready that accepts it. Nothing downstream can push back, so the whole pipe moves together on an issue or a drain step. The class and branch-target inputs must describe the instruction at `fetch_addr` and stay steady while it waits. A change on `turbo_i` is acted on only at a slot boundary. The pipe then drains before the new mode applies.

Top module: `pipe_seq`

## Requirements
- R1: While reset is asserted, `stage_vld` is 0, `fetch_addr` is 0, `turbo_active` is 0 (compatibility mode), and no retire, flush or issue strobe is raised.
- R2: The class code on `ins_cls` is 0 for ordinary, 1 for taken jump/call, 2 for instruction-memory read, and 3 behaves as ordinary. In compatibility mode an ordinary instruction holds `fetch_addr` for 4 clocks. A jump/call holds it for 7 clocks, and a one-clock refill bubble follows, giving 8 clocks in total.
- R3: In turbo mode an ordinary instruction holds `fetch_addr` for 1 clock, so the core issues one per clock. A jump/call holds it for 2 clocks, and a one-clock refill bubble follows, giving 3 clocks in total.
- R4: An instruction-memory read holds `fetch_addr` for 4 clocks in either mode.
- R5: When a jump/call issues, `flush_o` pulses for that one clock, `fetch_addr` loads `br_target` on the next edge, and `stage_vld[0]` is low for one clock after that.
- R6: On each issue, stage valids shift one place toward writeback (bit 0 fetch, bit 3 writeback). `stage_adv` marks each valid stage that hands on. `retire_o` pulses exactly when a valid writeback instruction leaves.
- R7: A request on `turbo_i` that differs from the active mode is taken only when no slot is part-way through. The decode, execute and writeback stages then drain one step per clock while `fetch_addr` and the fetch instruction hold. `turbo_active` changes on the clock after the last of them empties.
- R8: `fwd_hit` is high when `wb_we` is set, writeback and execute both hold valid instructions, and `wb_addr` equals `ex_raddr`. `ex_rdata` then equals `wb_wdata`; otherwise it equals `ram_rdata`.
- R9: The clock after reset is released, the fetch stage is still empty. On the following clock `stage_vld[0]` rises with `fetch_addr` still 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| turbo_i | input | 1 | Requested mode, 1 = turbo |
| ins_cls | input | 2 | Class of the instruction at fetch_addr |
| br_target | input | AW | Jump/call target of the instruction at fetch_addr |
| fetch_addr | output | AW | Current fetch address |
| issue_o | output | 1 | Fetch instruction accepted this clock |
| stage_vld | output | 4 | Valid per stage, bit 0 fetch to bit 3 writeback |
| stage_adv | output | 4 | Advance strobe per stage |
| flush_o | output | 1 | Younger fetch slot discarded by a jump/call |
| retire_o | output | 1 | A writeback instruction completed |
| turbo_active | output | 1 | Mode in force |
| wb_we | input | 1 | Writeback stage writes data RAM |
| wb_addr | input | RAW | Writeback write address |
| wb_wdata | input | DW | Writeback write data |
| ex_raddr | input | RAW | Execute stage read address |
| ram_rdata | input | DW | Data read from RAM for execute |
| ex_rdata | output | DW | Operand delivered to execute |
| fwd_hit | output | 1 | Forwarding path selected |

## Verification
The program fed to the sequencer mixes ordinary instructions, jumps to scattered targets and memory reads. It runs in a long compatibility stretch, a long turbo stretch and then a phase where the mode request toggles every few dozen clocks. The long stretches separate the per-class hold times of the two modes, including the bubble after a jump. The toggling phase tests that mode changes wait for a boundary and drain without losing or duplicating the waiting instruction. Writeback and execute addresses are cycled at different rates with the write enable gated on and off. This separates true forwarding hits from hits that a missing stage valid or a cleared write enable must suppress.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int NSTG  = 4;
  localparam int CNT_W = 3;

  typedef enum logic [1:0] {
    CLS_ORD = 2'd0,
    CLS_JMP = 2'd1,
    CLS_IRD = 2'd2,
    CLS_RSV = 2'd3
  } cls_e;

  localparam logic [CNT_W-1:0] HOLD_ORD_C = CNT_W'(4);
  localparam logic [CNT_W-1:0] HOLD_ORD_T = CNT_W'(1);
  localparam logic [CNT_W-1:0] HOLD_JMP_C = CNT_W'(7);
  localparam logic [CNT_W-1:0] HOLD_JMP_T = CNT_W'(2);
  localparam logic [CNT_W-1:0] HOLD_IRD   = CNT_W'(4);

  function automatic logic [CNT_W-1:0] slot_len(input logic turbo, input cls_e c);
    case (c)
      CLS_JMP: slot_len = turbo ? HOLD_JMP_T : HOLD_JMP_C;
      CLS_IRD: slot_len = HOLD_IRD;
      default: slot_len = turbo ? HOLD_ORD_T : HOLD_ORD_C;
    endcase
  endfunction
endpackage

// File: rtl/seq_slot.sv
module seq_slot import seq_pkg::*; #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          turbo_req,
  input  logic          fetch_ok,
  input  logic          pipe_busy,
  input  cls_e          cls,
  input  logic [AW-1:0] target,
  output logic [AW-1:0] pc,
  output logic          issue,
  output logic          drain,
  output logic          turbo
);
  logic [CNT_W-1:0] cnt_q, len;
  logic [AW-1:0]    pc_q;
  logic             drain_q, want_q, turbo_q;
  logic             start_drain, last_beat;

  always_comb begin
    len         = slot_len(turbo_q, cls);
    start_drain = !drain_q && (cnt_q == '0) && (turbo_req != turbo_q);
    last_beat   = (cnt_q == len - CNT_W'(1));
    issue       = !drain_q && !start_drain && fetch_ok && last_beat;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pc_q    <= '0;
      drain_q <= 1'b0;
      want_q  <= 1'b0;
      turbo_q <= 1'b0;
    end else begin
      if (start_drain) begin
        drain_q <= 1'b1;
        want_q  <= turbo_req;
      end else if (drain_q && !pipe_busy) begin
        drain_q <= 1'b0;
        turbo_q <= want_q;
      end
      if (issue) begin
        cnt_q <= '0;
        pc_q  <= (cls == CLS_JMP) ? target : pc_q + AW'(1);
      end else if (!drain_q && !start_drain && fetch_ok) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign pc    = pc_q;
  assign drain = drain_q;
  assign turbo = turbo_q;

  // R5
  jmp_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && cls == CLS_JMP) |=> (pc_q == $past(target)));
  // R7
  drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drain_q |=> $stable(pc_q));
  // R7
  mode_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !drain_q |=> $stable(turbo_q));
  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(7));
endmodule

// File: rtl/seq_stages.sv
module seq_stages import seq_pkg::*; (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue,
  input  logic            is_jmp,
  input  logic            drain,
  output logic [NSTG-1:0] vld,
  output logic [NSTG-1:0] adv,
  output logic            retire,
  output logic            flush
);
  logic [NSTG-1:0] vld_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     vld_q <= '0;
    else if (drain) vld_q <= {vld_q[NSTG-2:1], 1'b0, vld_q[0]};
    else if (issue) vld_q <= {vld_q[NSTG-2:0], ~is_jmp};
    else            vld_q <= {vld_q[NSTG-1:1], 1'b1};
  end

  always_comb begin
    if (drain)      adv = {vld_q[NSTG-1:1], 1'b0};
    else if (issue) adv = vld_q;
    else            adv = '0;
  end

  assign vld    = vld_q;
  assign retire = adv[NSTG-1];
  assign flush  = issue && is_jmp;

  // R5
  flush_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !vld_q[0]);
  // R7
  drain_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drain |=> !vld_q[1]);
  // R6
  retire_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retire |=> (vld_q[NSTG-1] == $past(vld_q[NSTG-2])));
endmodule

// File: rtl/seq_fwd.sv
module seq_fwd #(
  parameter int RAW = 6,
  parameter int DW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wb_ok,
  input  logic           ex_ok,
  input  logic           wb_we,
  input  logic [RAW-1:0] wb_addr,
  input  logic [DW-1:0]  wb_wdata,
  input  logic [RAW-1:0] ex_addr,
  input  logic [DW-1:0]  ram_rdata,
  output logic [DW-1:0]  rdata,
  output logic           hit
);
  always_comb begin
    hit   = wb_we && wb_ok && ex_ok && (wb_addr == ex_addr);
    rdata = hit ? wb_wdata : ram_rdata;
  end

  // R8
  fwd_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wb_we |-> (rdata == ram_rdata));
endmodule

// File: rtl/pipe_seq.sv
module pipe_seq import seq_pkg::*; #(
  parameter int AW  = 10,
  parameter int RAW = 6,
  parameter int DW  = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            turbo_i,
  input  logic [1:0]      ins_cls,
  input  logic [AW-1:0]   br_target,
  output logic [AW-1:0]   fetch_addr,
  output logic            issue_o,
  output logic [NSTG-1:0] stage_vld,
  output logic [NSTG-1:0] stage_adv,
  output logic            flush_o,
  output logic            retire_o,
  output logic            turbo_active,
  input  logic            wb_we,
  input  logic [RAW-1:0]  wb_addr,
  input  logic [DW-1:0]   wb_wdata,
  input  logic [RAW-1:0]  ex_raddr,
  input  logic [DW-1:0]   ram_rdata,
  output logic [DW-1:0]   ex_rdata,
  output logic            fwd_hit
);
  localparam int WB = NSTG - 1;
  localparam int EX = NSTG - 2;

  cls_e cls;
  logic issue, drain, pipe_busy;

  assign cls       = cls_e'(ins_cls);
  assign pipe_busy = |stage_vld[EX:1];

  seq_slot #(.AW(AW)) u_slot (
    .clk(clk), .rst_n(rst_n), .turbo_req(turbo_i), .fetch_ok(stage_vld[0]),
    .pipe_busy(pipe_busy), .cls(cls), .target(br_target), .pc(fetch_addr),
    .issue(issue), .drain(drain), .turbo(turbo_active)
  );

  seq_stages u_stg (
    .clk(clk), .rst_n(rst_n), .issue(issue), .is_jmp(cls == CLS_JMP),
    .drain(drain), .vld(stage_vld), .adv(stage_adv), .retire(retire_o),
    .flush(flush_o)
  );

  seq_fwd #(.RAW(RAW), .DW(DW)) u_fwd (
    .clk(clk), .rst_n(rst_n), .wb_ok(stage_vld[WB]), .ex_ok(stage_vld[EX]),
    .wb_we(wb_we), .wb_addr(wb_addr), .wb_wdata(wb_wdata), .ex_addr(ex_raddr),
    .ram_rdata(ram_rdata), .rdata(ex_rdata), .hit(fwd_hit)
  );

  assign issue_o = issue;
endmodule

// File: tb/sim_pipe_seq.sv
module sim_pipe_seq;
  localparam int PER = 10;
  localparam int AW  = 10;
  localparam int RAW = 6;
  localparam int DW  = 8;
  localparam int NCYC = 1600;

  logic clk = 1'b0, rst_n = 1'b0;
  logic turbo_i = 1'b0;
  logic [1:0] ins_cls = '0;
  logic [AW-1:0] br_target = '0, fetch_addr;
  logic issue_o, flush_o, retire_o, turbo_active, fwd_hit;
  logic [3:0] stage_vld, stage_adv;
  logic wb_we = 1'b0;
  logic [RAW-1:0] wb_addr = '0, ex_raddr = '0;
  logic [DW-1:0] wb_wdata = '0, ram_rdata = '0, ex_rdata;

  int total = 0, bad = 0;
  bit done = 0;

  always #(PER/2) clk = ~clk;

  pipe_seq #(.AW(AW), .RAW(RAW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .turbo_i(turbo_i), .ins_cls(ins_cls),
    .br_target(br_target), .fetch_addr(fetch_addr), .issue_o(issue_o),
    .stage_vld(stage_vld), .stage_adv(stage_adv), .flush_o(flush_o),
    .retire_o(retire_o), .turbo_active(turbo_active), .wb_we(wb_we),
    .wb_addr(wb_addr), .wb_wdata(wb_wdata), .ex_raddr(ex_raddr),
    .ram_rdata(ram_rdata), .ex_rdata(ex_rdata), .fwd_hit(fwd_hit)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int cls_of(int a);
    if (a % 9 == 4) return 1;
    if (a % 5 == 2) return 2;
    return 0;
  endfunction

  function automatic int tgt_of(int a);
    return (a * 7 + 3) % 50;
  endfunction

  // clocks the fetch address is held, per mode and class
  function automatic int hold_of(int tb, int c);
    int whole;
    if (c == 2) whole = 4;
    else if (c == 1) whole = tb ? 3 : 8;
    else whole = tb ? 1 : 4;
    return (c == 1) ? whole - 1 : whole;
  endfunction

  function automatic int turbo_at(int cyc);
    if (cyc < 300) return 0;
    if (cyc < 800) return 1;
    if (cyc < 900) return 0;
    if (cyc < 1400) return (cyc / 37) % 2;
    return 1;
  endfunction

  initial begin
    #(PER * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int m_pc, m_cnt, m_drain, m_want, m_mode;
    logic [3:0] m_v, nv, e_adv;
    int last_addr, seg_start, seg_mode;
    bit seg_ok, first_seg, prev_jmp;
    int n_sp[2][3];
    m_pc = 0; m_cnt = 0; m_drain = 0; m_want = 0; m_mode = 0; m_v = '0;
    last_addr = 0; seg_start = 0; seg_mode = 0; seg_ok = 0; first_seg = 1; prev_jmp = 0;
    foreach (n_sp[i, j]) n_sp[i][j] = 0;

    repeat (3) @(negedge clk);
    #1;
    chk(stage_vld == 4'b0, "R1 stage_vld in reset", int'(stage_vld), 0);
    chk(fetch_addr == '0, "R1 fetch_addr in reset", int'(fetch_addr), 0);
    chk(turbo_active == 1'b0, "R1 mode in reset", int'(turbo_active), 0);
    chk(!retire_o && !flush_o && !issue_o, "R1 strobes in reset",
        int'({retire_o, flush_o, issue_o}), 0);

    for (int cyc = 0; cyc < NCYC; cyc++) begin
      int c, len, hit_e;
      bit start, iss, drn, jmp;
      @(negedge clk);
      if (cyc == 0) rst_n = 1'b1;
      turbo_i   = 1'(turbo_at(cyc));
      ins_cls   = 2'(cls_of(m_pc));
      br_target = AW'(tgt_of(m_pc));
      wb_we     = (cyc % 3) != 0;
      wb_addr   = RAW'(cyc % 4);
      ex_raddr  = RAW'((cyc / 2) % 4);
      wb_wdata  = DW'(cyc);
      ram_rdata = DW'(~cyc);
      #1;
      c     = cls_of(m_pc);
      jmp   = (c == 1);
      len   = hold_of(m_mode, c);
      drn   = (m_drain != 0);
      start = !drn && m_cnt == 0 && (int'(turbo_i) != m_mode);
      iss   = !drn && !start && m_v[0] && (m_cnt == len - 1);
      if (drn) e_adv = {m_v[3:1], 1'b0};
      else if (iss) e_adv = m_v;
      else e_adv = 4'b0;
      hit_e = wb_we && m_v[3] && m_v[2] && (int'(wb_addr) == int'(ex_raddr));

      if (cyc == 0) chk(stage_vld[0] == 1'b0, "R9 fetch empty first clock", int'(stage_vld[0]), 0);
      if (cyc == 1) chk(stage_vld[0] == 1'b1 && fetch_addr == '0, "R9 fetch valid at zero",
                        int'({stage_vld[0], fetch_addr}), 1 << AW);
      chk(int'(fetch_addr) == m_pc, m_mode ? "R3 fetch_addr" : "R2 fetch_addr", int'(fetch_addr), m_pc);
      chk(stage_vld == m_v, "R6 stage_vld", int'(stage_vld), int'(m_v));
      chk(stage_adv == e_adv, "R6 stage_adv", int'(stage_adv), int'(e_adv));
      chk(retire_o == e_adv[3], "R6 retire", int'(retire_o), int'(e_adv[3]));
      chk(issue_o == iss, "R6 issue", int'(issue_o), int'(iss));
      chk(flush_o == (iss && jmp), "R5 flush", int'(flush_o), int'(iss && jmp));
      chk(int'(turbo_active) == m_mode, "R7 mode", int'(turbo_active), m_mode);
      chk(int'(fwd_hit) == hit_e, "R8 fwd_hit", int'(fwd_hit), hit_e);
      chk(ex_rdata == (hit_e ? wb_wdata : ram_rdata), "R8 ex_rdata", int'(ex_rdata),
          int'(hit_e ? wb_wdata : ram_rdata));

      // hold-time check of each fetch address, independent of the per-clock model
      if (int'(fetch_addr) != last_addr) begin
        if (seg_ok && !first_seg) begin
          int lc, ex;
          lc = cls_of(last_addr);
          ex = hold_of(seg_mode, lc) + (prev_jmp ? 1 : 0);
          n_sp[seg_mode][lc]++;
          if (lc == 2) chk(cyc - seg_start == ex, "R4 read hold", cyc - seg_start, ex);
          else if (seg_mode != 0) chk(cyc - seg_start == ex, "R3 turbo hold", cyc - seg_start, ex);
          else chk(cyc - seg_start == ex, "R2 compat hold", cyc - seg_start, ex);
        end
        if (!first_seg || seg_ok) prev_jmp = (cls_of(last_addr) == 1);
        first_seg = (seg_start == 0 && !seg_ok) ? 1'b0 : first_seg;
        if (!seg_ok && seg_start == 0) first_seg = 1'b1;
        last_addr = int'(fetch_addr);
        seg_start = cyc;
        seg_mode  = m_mode;
        seg_ok    = 1'b1;
        if (cyc > 0 && last_addr != 0) first_seg = 1'b0;
      end
      if (drn || start) seg_ok = 1'b0;

      // advance the reference model
      if (drn) nv = {m_v[2:1], 1'b0, m_v[0]};
      else if (iss) nv = {m_v[2:0], ~jmp};
      else nv = {m_v[3:1], 1'b1};
      if (start) begin
        m_drain = 1; m_want = int'(turbo_i);
      end else if (drn && m_v[2:1] == 2'b0) begin
        m_drain = 0; m_mode = m_want;
      end
      if (iss) begin
        m_cnt = 0;
        m_pc  = jmp ? tgt_of(m_pc) : (m_pc + 1) % (1 << AW);
      end else if (!drn && !start && m_v[0]) begin
        m_cnt++;
      end
      m_v = nv;
    end

    chk(n_sp[0][0] > 0, "R2 compat ordinary seen", n_sp[0][0], 1);
    chk(n_sp[0][1] > 0, "R2 compat jump seen", n_sp[0][1], 1);
    chk(n_sp[1][0] > 0, "R3 turbo ordinary seen", n_sp[1][0], 1);
    chk(n_sp[1][1] > 0, "R3 turbo jump seen", n_sp[1][1], 1);
    chk(n_sp[0][2] > 0, "R4 compat read seen", n_sp[0][2], 1);
    chk(n_sp[1][2] > 0, "R4 turbo read seen", n_sp[1][2], 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule